// File: doc/BRIEF.md
# Serial Programming Register with Latch Decode

This block takes a serial word from a three-wire programming port: a data line, a serial clock, and a load strobe. While the serial clock toggles, one data bit enters a 22-bit shift register on each rising serial-clock edge, most-significant bit first. A rising edge on the load strobe then copies the assembled word into one of four holding latches. The two lowest bits of the word select the latch.

The four latches feed the dividers of two independent synthesizer channels, an intermediate-frequency (IF) channel and a radio-frequency (RF) channel. Each channel has a reference-divider latch and a swallow/prescaler-count latch. Each latch presents the 20 payload bits above the control field. For the two reference latches, the divide value is also brought out on its own port.

The three serial lines are treated as asynchronous to the block clock. Each line passes through a synchronizer, and edges are found in the block clock domain. The serial clock and the load strobe must therefore each hold every level for at least three block-clock cycles.

Top module: `serial_prog_reg`

## Requirements
- R1: Reset clears all four latches to zero and also clears the shift register, so that bits shifted in after reset combine only with zeros.
- R2: Each rising serial-clock edge shifts the register up by one place and puts the data bit in bit 0. The first bit sent therefore ends up in bit 21 after 22 edges.
- R3: Falling serial-clock edges, and changes of the data line while the serial clock is steady, leave the shift register unchanged.
- R4: A latch is written only on a rising edge of the load strobe. Holding the strobe high while more bits are shifted in, or dropping it, changes no latch.
- R5: Word bits [1:0] select the destination latch: 00 selects the IF reference latch, 01 the IF count latch, 10 the RF reference latch, and 11 the RF count latch. The selected latch takes word bits [21:2].
- R6: On a load edge, the three latches that are not selected keep their previous contents.
- R7: When more than 22 bits are shifted in before a load edge, only the last 22 bits reach the latch.
- R8: Each reference divide port shows bits [REF_DIV_W+1:2] of the word last loaded into that channel's reference latch, which is 14 bits by default (ratios up to 16383). REF_DIV_W = 15 extends the range to 32767.
- R9: Latch outputs change only in the block-clock cycle that follows a detected load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; a rising edge writes a latch |
| if_ref_pay | output | PAY_W (20) | IF reference latch payload |
| if_cnt_pay | output | PAY_W (20) | IF count/prescaler latch payload |
| rf_ref_pay | output | PAY_W (20) | RF reference latch payload |
| rf_cnt_pay | output | PAY_W (20) | RF count/prescaler latch payload |
| if_ref_div | output | REF_DIV_W (14) | IF reference divide value |
| rf_ref_div | output | REF_DIV_W (14) | RF reference divide value |

## Verification
The vector table sends words that target each of the four control codes, in an order that revisits latches. A word that lands in the wrong latch, or that disturbs a neighbour, therefore shows up against the bench model. The payloads are all-ones, all-zeros, alternating bits and sparse single bits, which separate a bit-order or off-by-one shift fault from a decode fault. Every bit is also sent with the data line flipped while the serial clock is high, which exposes sampling on the wrong edge or on level. Directed cases cover these corners:
- a load strobe held high through a whole new word;
- a 30-bit overlong frame;
- a short three-bit frame after reset, which reveals any shift-register bits that reset left behind.

// File: rtl/serial_prog_pkg.sv
package serial_prog_pkg;

  localparam int N_LATCH = 4;

  typedef enum logic [1:0] {
    SEL_IF_REF = 2'b00,
    SEL_IF_CNT = 2'b01,
    SEL_RF_REF = 2'b10,
    SEL_RF_CNT = 2'b11
  } latch_sel_e;

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;
  logic [W-1:0]             prev_q;
  logic [W-1:0]             prev_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
    prev_d = stg_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= prev_d;
    end
  end

  assign dout = stg_q[LAST];
  assign rise = stg_q[LAST] & ~prev_q;

endmodule

// File: rtl/sp_shift_reg.sv
module sp_shift_reg #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  always_comb begin
    q_d = q_r;
    if (shift_en) begin
      q_d = {q_r[W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/sp_latch_bank.sv
module sp_latch_bank
  import serial_prog_pkg::*;
#(
  parameter int WORD_W = 22,
  parameter int CTRL_W = 2,
  parameter int PAY_W  = WORD_W - CTRL_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_en,
  input  logic [WORD_W-1:0]               word_in,
  output logic [N_LATCH-1:0]              wr_en,
  output logic [N_LATCH-1:0][PAY_W-1:0]   pay_q
);

  logic [CTRL_W-1:0] sel;
  logic [PAY_W-1:0]  pay_in;

  assign sel    = word_in[CTRL_W-1:0];
  assign pay_in = word_in[WORD_W-1:CTRL_W];

  for (genvar g = 0; g < N_LATCH; g++) begin : g_latch
    logic [PAY_W-1:0] d;
    logic [PAY_W-1:0] r;

    always_comb begin
      wr_en[g] = load_en && (sel == CTRL_W'(g));
      d        = r;
      if (wr_en[g]) begin
        d = pay_in;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else begin
        r <= d;
      end
    end

    assign pay_q[g] = r;
  end

endmodule

// File: rtl/serial_prog_reg.sv
module serial_prog_reg
  import serial_prog_pkg::*;
#(
  parameter int WORD_W      = 22,
  parameter int CTRL_W      = 2,
  parameter int REF_DIV_W   = 14,
  parameter int SYNC_STAGES = 2,
  localparam int PAY_W      = WORD_W - CTRL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_data,
  input  logic                 ser_load,
  output logic [PAY_W-1:0]     if_ref_pay,
  output logic [PAY_W-1:0]     if_cnt_pay,
  output logic [PAY_W-1:0]     rf_ref_pay,
  output logic [PAY_W-1:0]     rf_cnt_pay,
  output logic [REF_DIV_W-1:0] if_ref_div,
  output logic [REF_DIV_W-1:0] rf_ref_div
);

  localparam int IDX_DATA = 0;
  localparam int IDX_SCLK = 1;
  localparam int IDX_LOAD = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_q;
  logic rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign rst_n_i = rst_sync_q;

  logic [2:0]              pins;
  logic [2:0]              pins_s;
  logic [2:0]              pins_rise;
  logic                    shift_pulse;
  logic                    load_pulse;
  logic [WORD_W-1:0]       shreg;
  logic [N_LATCH-1:0]      wr_en;
  logic [N_LATCH-1:0][PAY_W-1:0] pay_q;

  assign pins = {ser_load, ser_clk, ser_data};

  sp_sync_edge #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (pins),
    .dout  (pins_s),
    .rise  (pins_rise)
  );

  assign shift_pulse = pins_rise[IDX_SCLK];
  assign load_pulse  = pins_rise[IDX_LOAD];

  sp_shift_reg #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .shift_en (shift_pulse),
    .bit_in   (pins_s[IDX_DATA]),
    .q        (shreg)
  );

  sp_latch_bank #(.WORD_W(WORD_W), .CTRL_W(CTRL_W), .PAY_W(PAY_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .load_en (load_pulse),
    .word_in (shreg),
    .wr_en   (wr_en),
    .pay_q   (pay_q)
  );

  assign if_ref_pay = pay_q[SEL_IF_REF];
  assign if_cnt_pay = pay_q[SEL_IF_CNT];
  assign rf_ref_pay = pay_q[SEL_RF_REF];
  assign rf_cnt_pay = pay_q[SEL_RF_CNT];
  assign if_ref_div = pay_q[SEL_IF_REF][REF_DIV_W-1:0];
  assign rf_ref_div = pay_q[SEL_RF_REF][REF_DIV_W-1:0];

endmodule

// File: rtl/serial_prog_reg_chk.sv
module serial_prog_reg_chk
  import serial_prog_pkg::*;
#(
  parameter int WORD_W = 22,
  parameter int CTRL_W = 2,
  parameter int PAY_W  = WORD_W - CTRL_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rst_n_i,
  input logic                          shift_pulse,
  input logic                          load_pulse,
  input logic                          bit_in,
  input logic [WORD_W-1:0]             shreg,
  input logic [N_LATCH-1:0]            wr_en,
  input logic [N_LATCH-1:0][PAY_W-1:0] pay_q
);

  // R1: latches and shift register are zero while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (pay_q == '0 && shreg == '0)
        else $error("latches or shift register not cleared in reset");
    end
  end

  // R2: shift up with the new bit at the bottom
  p_shift_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    shift_pulse |=> shreg == {$past(shreg[WORD_W-2:0]), $past(bit_in)});

  // R3: no serial edge, no change
  p_shift_hold_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    !shift_pulse |=> $stable(shreg));

  // R6: at most one latch written per edge
  p_single_write_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(wr_en));

  // R4: writes only accompany a load edge
  p_write_needs_load_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en != '0) |-> load_pulse);

  for (genvar g = 0; g < N_LATCH; g++) begin : g_lat
    // R5: selected latch receives the payload
    p_route_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
      (load_pulse && shreg[CTRL_W-1:0] == CTRL_W'(g))
        |=> pay_q[g] == $past(shreg[WORD_W-1:CTRL_W]));
    // R9: a latch moves only after its write
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
      !wr_en[g] |=> $stable(pay_q[g]));
  end

endmodule

bind serial_prog_reg serial_prog_reg_chk #(
  .WORD_W (WORD_W),
  .CTRL_W (CTRL_W),
  .PAY_W  (PAY_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_n_i     (rst_n_i),
  .shift_pulse (shift_pulse),
  .load_pulse  (load_pulse),
  .bit_in      (pins_s[0]),
  .shreg       (shreg),
  .wr_en       (wr_en),
  .pay_q       (pay_q)
);

// File: tb/serial_prog_reg_bench.sv
module serial_prog_reg_bench;

  localparam int WORD_W = 22;
  localparam int PAY_W  = 20;
  localparam int DIV_W  = 14;
  localparam int H      = 4;
  localparam int NVEC   = 8;

  localparam logic [WORD_W-1:0] VEC_WORD [NVEC] = '{
    22'h3FFFFC, 22'h000001, 22'h2AAAAA, 22'h155557,
    22'h0DEAD1, 22'h30F0F0, 22'h0FFFF2, 22'h20000F
  };
  localparam logic [1:0] VEC_SEL [NVEC] = '{
    2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd0, 2'd2, 2'd3
  };

  logic clk;
  logic rst_n;
  logic ser_clk;
  logic ser_data;
  logic ser_load;
  logic [PAY_W-1:0] if_ref_pay, if_cnt_pay, rf_ref_pay, rf_cnt_pay;
  logic [DIV_W-1:0] if_ref_div, rf_ref_div;

  logic [PAY_W-1:0] exp_pay [4];
  int checks;
  int fails;

  serial_prog_reg u_serial_prog_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .ser_load   (ser_load),
    .if_ref_pay (if_ref_pay),
    .if_cnt_pay (if_cnt_pay),
    .rf_ref_pay (rf_ref_pay),
    .rf_cnt_pay (rf_cnt_pay),
    .if_ref_div (if_ref_div),
    .rf_ref_div (rf_ref_div)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " if_ref"}, 32'(if_ref_pay), 32'(exp_pay[0]));
    check({tag, " if_cnt"}, 32'(if_cnt_pay), 32'(exp_pay[1]));
    check({tag, " rf_ref"}, 32'(rf_ref_pay), 32'(exp_pay[2]));
    check({tag, " rf_cnt"}, 32'(rf_cnt_pay), 32'(exp_pay[3]));
    check({tag, " R8 if_div"}, 32'(if_ref_div), 32'(exp_pay[0][DIV_W-1:0]));
    check({tag, " R8 rf_div"}, 32'(rf_ref_div), 32'(exp_pay[2][DIV_W-1:0]));
  endtask

  // sends bits MSB first; data flips while clock is high (R3 stimulus)
  task automatic send_bits(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      hold(H);
      ser_clk = 1'b1;
      hold(H);
      ser_data = ~bits[i];
      hold(H);
      ser_clk = 1'b0;
      hold(H);
    end
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    hold(H);
    ser_load = 1'b0;
    hold(2 * H);
  endtask

  task automatic clear_model();
    for (int k = 0; k < 4; k++) exp_pay[k] = '0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n = 1'b0;
    ser_clk = 1'b0;
    ser_data = 1'b0;
    ser_load = 1'b0;
    clear_model();
    hold(4);
    check_all("R1 reset");
    rst_n = 1'b1;
    hold(4);

    // table: R2 R3 R5 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      send_bits(64'(VEC_WORD[v]), WORD_W);
      pulse_load();
      exp_pay[VEC_SEL[v]] = VEC_WORD[v][WORD_W-1:2];
      check_all($sformatf("R5 R6 vec%0d", v));
    end

    // R4: load held high while a new word is shifted in
    ser_load = 1'b1;
    hold(2 * H);
    send_bits(64'(22'h123450), WORD_W);
    check_all("R4 held high");
    ser_load = 1'b0;
    hold(2 * H);
    check_all("R4 falling edge");
    pulse_load();
    exp_pay[0] = 20'h48D14;
    check_all("R4 rising edge");

    // R7: 30 bits, the last 22 land
    send_bits({34'd0, 8'hFF, 22'h05A5A6}, 30);
    pulse_load();
    exp_pay[2] = 22'h05A5A6 >> 2;
    check_all("R7 overlong");

    // R1: reset clears the shift register
    send_bits(64'(22'h3FFFFF), WORD_W);
    rst_n = 1'b0;
    hold(2);
    clear_model();
    check_all("R1 second reset");
    rst_n = 1'b1;
    hold(4);
    send_bits(64'h7, 3);
    pulse_load();
    exp_pay[3] = 20'h1;
    check_all("R1 short frame after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule